// File: doc/BRIEF.md
# Byte-Bus Line Cache with Wait-State

This block connects an 8-bit requester, which issues one byte read or one byte write at a time, to a slow memory that returns whole 16-byte lines. It keeps a single line of the most recently fetched memory. A read that falls inside that line is answered from the buffer one cycle later, and the slow memory sees no traffic. A read outside the line stalls the requester with a wait signal while the line is fetched. When the line arrives it is stored, and the requested byte is returned with a one-cycle ready strobe.

Writes always pass through to the slow memory. If a write hits the held line, the stored byte is patched. Every write that goes out is also driven onto a mirror port for an on-chip RAM copy. The requester keeps its request, address and write data steady until it sees wait low in a cycle; that cycle accepts the request. It never asserts read and write together.

Top module: `byte_line_cache`

## Requirements
- R1: After reset, cpuWait, cpuRdReady, memReq and mirWe are low while no request is presented, and the line is marked empty.
- R2: The first read after reset is treated as a miss and fetches a line, whatever its address.
- R3: A read whose address, with its low 4 bits dropped, equals the held line's tag sees cpuWait low in its request cycle. cpuRdReady pulses in the next cycle with that byte, and memReq stays low.
- R4: A read outside the held line raises cpuWait in the same cycle. A fetch is then requested (memReq high, memWrite low, memAddr equal to the read address with its low 4 bits cleared), and it is held while memBusy is high. The fetch is accepted in the first cycle where memReq is high and memBusy is low.
- R5: On memRdValid, the 128-bit memRdLine is stored, with byte i of the line at bits 8i+7 down to 8i. In the next cycle, cpuRdReady pulses for one cycle with the requested byte, and cpuWait is low for the pending read in that cycle.
- R6: Only one fetch is outstanding: after a fetch is accepted, memReq stays low until the line has been returned.
- R7: A write is accepted in a cycle where memBusy is low. In that cycle memReq and memWrite are high, memAddr is the byte address and memWrData is the data. While memBusy is high, cpuWait is high for the write.
- R8: In every cycle a write goes to the slow memory, mirWe is high and mirAddr and mirData carry the same address and data.
- R9: A write inside the held line updates that byte, so that a later hit returns the new value. A write outside it leaves the held line unchanged.
- R10: A write presented while a fetch is outstanding sees cpuWait high and reaches neither memory port until the fetch has completed and its ready strobe has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuRdReq | input | 1 | Byte read request, held until wait is low |
| cpuWrReq | input | 1 | Byte write request, held until wait is low |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWrData | input | 8 | Write data |
| cpuWait | output | 1 | Stall toward the requester |
| cpuRdReady | output | 1 | One-cycle read data valid strobe |
| cpuRdData | output | 8 | Read data byte |
| memReq | output | 1 | Slow-memory command request |
| memWrite | output | 1 | Command is a byte write (else a line fetch) |
| memAddr | output | ADDR_W | Command address |
| memWrData | output | 8 | Write byte to slow memory |
| memBusy | input | 1 | Slow memory cannot take a command |
| memRdValid | input | 1 | Fetched line is present on memRdLine |
| memRdLine | input | 8*LINE_BYTES | Fetched line |
| mirWe | output | 1 | Mirror RAM write enable |
| mirAddr | output | ADDR_W | Mirror RAM address |
| mirData | output | 8 | Mirror RAM data |

## Verification
Two of the block's functions can fall in the same cycle here. A line fill can complete in the cycle in which a write is waiting. A write can also hit the line that was just filled. The bench starts a miss, withdraws the read while the fetch is outstanding and presents a write to that same line. It then judges that the write is held through the fill and the ready pulse, is accepted on the following idle cycle with its mirror copy, and patches the freshly loaded line. A hit read of that byte then returns the written value. The bench also varies memBusy around fetches and writes, so that held-off commands are compared cycle by cycle.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH    = 2'd1,
    ST_WAITLINE = 2'd2,
    ST_DONE     = 2'd3
  } ctrl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchMiss;  // capture missing read address
    logic fillLine;   // store returned line, load requested byte
    logic writeByte;  // patch one byte of held line
    logic loadHit;    // load hit byte into read register
  } dp_ctl_t;

endpackage

// File: rtl/cache_dp.sv
module cache_dp
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dp_ctl_t                 ctl,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [7:0]              cpuWrData,
  input  logic [8*LINE_BYTES-1:0] memRdLine,
  output logic                    lineHit,
  output logic [ADDR_W-1:0]       missAddr,
  output logic [7:0]              rdData
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic                    lineValid;
  logic [TAG_W-1:0]        lineTag;
  logic [8*LINE_BYTES-1:0] lineVec;
  logic [OFF_W-1:0]        cpuOff;
  logic [OFF_W-1:0]        missOff;

  assign cpuOff  = cpuAddr[OFF_W-1:0];
  assign missOff = missAddr[OFF_W-1:0];
  assign lineHit = lineValid && (lineTag == cpuAddr[ADDR_W-1:OFF_W]);

  // one storage lane per byte of the line
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk) begin
      if (ctl.fillLine)
        laneQ <= memRdLine[8*b +: 8];
      else if (ctl.writeByte && cpuOff == OFF_W'(b))
        laneQ <= cpuWrData;
    end
    assign lineVec[8*b +: 8] = laneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= 1'b0;
      lineTag   <= '0;
      missAddr  <= '0;
      rdData    <= '0;
    end else begin
      if (ctl.latchMiss) missAddr <= cpuAddr;
      if (ctl.fillLine) begin
        lineValid <= 1'b1;
        lineTag   <= missAddr[ADDR_W-1:OFF_W];
        rdData    <= memRdLine[8*missOff +: 8];
      end else if (ctl.loadHit) begin
        rdData    <= lineVec[8*cpuOff +: 8];
      end
    end
  end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuRdReq,
  input  logic        cpuWrReq,
  input  logic        lineHit,
  input  logic        memBusy,
  input  logic        memRdValid,
  output dp_ctl_t     ctl,
  output ctrl_state_t ctrlState,
  output logic        cpuWait,
  output logic        cpuRdReady,
  output logic        memReq,
  output logic        memWrite,
  output logic        selFetch
);

  ctrl_state_t nextState;

  always_comb begin
    ctl       = '0;
    nextState = ctrlState;
    cpuWait   = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    selFetch  = 1'b0;
    unique case (ctrlState)
      ST_IDLE: begin
        if (cpuRdReq) begin
          cpuWait       = !lineHit;
          ctl.loadHit   = lineHit;
          ctl.latchMiss = !lineHit;
          if (!lineHit) nextState = ST_FETCH;
        end else if (cpuWrReq) begin
          cpuWait = memBusy;
          if (!memBusy) begin
            memReq        = 1'b1;
            memWrite      = 1'b1;
            ctl.writeByte = lineHit;
          end
        end
      end
      ST_FETCH: begin
        cpuWait  = 1'b1;
        selFetch = 1'b1;
        memReq   = !memBusy;
        if (!memBusy) nextState = ST_WAITLINE;
      end
      ST_WAITLINE: begin
        cpuWait = 1'b1;
        if (memRdValid) begin
          ctl.fillLine = 1'b1;
          nextState    = ST_DONE;
        end
      end
      ST_DONE: begin
        // pending read is answered here; a write waits one more cycle
        cpuWait   = cpuWrReq;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlState  <= ST_IDLE;
      cpuRdReady <= 1'b0;
    end else begin
      ctrlState  <= nextState;
      cpuRdReady <= ctl.loadHit | ctl.fillLine;
    end
  end

endmodule

// File: rtl/byte_line_cache.sv
module byte_line_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuRdReq,
  input  logic                    cpuWrReq,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [7:0]              cpuWrData,
  output logic                    cpuWait,
  output logic                    cpuRdReady,
  output logic [7:0]              cpuRdData,
  output logic                    memReq,
  output logic                    memWrite,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [7:0]              memWrData,
  input  logic                    memBusy,
  input  logic                    memRdValid,
  input  logic [8*LINE_BYTES-1:0] memRdLine,
  output logic                    mirWe,
  output logic [ADDR_W-1:0]       mirAddr,
  output logic [7:0]              mirData
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  dp_ctl_t           dpCtl;
  ctrl_state_t       ctrlState;
  logic              lineHit;
  logic              selFetch;
  logic [ADDR_W-1:0] missAddr;

  cache_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuRdReq   (cpuRdReq),
    .cpuWrReq   (cpuWrReq),
    .lineHit    (lineHit),
    .memBusy    (memBusy),
    .memRdValid (memRdValid),
    .ctl        (dpCtl),
    .ctrlState  (ctrlState),
    .cpuWait    (cpuWait),
    .cpuRdReady (cpuRdReady),
    .memReq     (memReq),
    .memWrite   (memWrite),
    .selFetch   (selFetch)
  );

  cache_dp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .memRdLine (memRdLine),
    .lineHit   (lineHit),
    .missAddr  (missAddr),
    .rdData    (cpuRdData)
  );

  assign memAddr   = selFetch ? {missAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : cpuAddr;
  assign memWrData = cpuWrData;
  assign mirWe     = memReq & memWrite;
  assign mirAddr   = cpuAddr;
  assign mirData   = cpuWrData;

endmodule

// File: rtl/cache_checker.sv
module cache_checker
  import cache_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuRdReq,
  input logic              cpuWrReq,
  input logic              cpuWait,
  input logic              cpuRdReady,
  input logic              memReq,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWrData,
  input logic              memBusy,
  input logic              memRdValid,
  input logic              mirWe,
  input logic [ADDR_W-1:0] mirAddr,
  input logic [7:0]        mirData,
  input logic              lineHit,
  input ctrl_state_t       ctrlState
);

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdReq && !cpuWait) |-> !memReq);  // R3

  AST_HIT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE && cpuRdReq && !cpuWait) |=> cpuRdReady);  // R3

  AST_MISS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE && cpuRdReq && !lineHit) |-> cpuWait);  // R4

  AST_FILL_READY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_WAITLINE && memRdValid) |=> cpuRdReady);  // R5

  AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && !memBusy) |=> !memReq);  // R6

  AST_BUSY_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrReq && memBusy) |-> cpuWait);  // R7

  AST_MIRROR_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> (mirWe && mirAddr == memAddr && mirData == memWrData));  // R8

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrReq && ctrlState != ST_IDLE) |-> (cpuWait && !mirWe));  // R10

endmodule

bind byte_line_cache cache_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuRdReq   (cpuRdReq),
  .cpuWrReq   (cpuWrReq),
  .cpuWait    (cpuWait),
  .cpuRdReady (cpuRdReady),
  .memReq     (memReq),
  .memWrite   (memWrite),
  .memAddr    (memAddr),
  .memWrData  (memWrData),
  .memBusy    (memBusy),
  .memRdValid (memRdValid),
  .mirWe      (mirWe),
  .mirAddr    (mirAddr),
  .mirData    (mirData),
  .lineHit    (lineHit),
  .ctrlState  (ctrlState)
);

// File: tb/test_byte_line_cache.sv
module test_byte_line_cache;

  localparam int AW  = 16;
  localparam int LB  = 16;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cpuRdReq, cpuWrReq;
  logic [AW-1:0] cpuAddr;
  logic [7:0]    cpuWrData;
  logic          cpuWait, cpuRdReady;
  logic [7:0]    cpuRdData;
  logic          memReq, memWrite;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWrData;
  logic          memBusy, memRdValid;
  logic [8*LB-1:0] memRdLine;
  logic          mirWe;
  logic [AW-1:0] mirAddr;
  logic [7:0]    mirData;

  always #2 clk = ~clk;  // 250 MHz

  byte_line_cache #(.ADDR_W(AW), .LINE_BYTES(LB)) i_byte_line_cache (.*);

  int vectors = 0;
  int fails   = 0;

  // behavioural reference state
  int           mSt;     // 0 idle, 1 fetch, 2 waiting for line, 3 answering
  bit           mValid;
  int           mTag;
  byte unsigned mLine [LB];
  int           mMiss;
  bit           mRdy;
  byte unsigned mData;
  byte unsigned memArr [int];
  int           busyLeft;
  int           lat;

  function automatic byte unsigned memByte(int a);
    if (memArr.exists(a)) return memArr[a];
    return 8'((a * 13) ^ (a >> 8) ^ 8'h5A);
  endfunction

  task automatic chk(string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  // one clock cycle: drive responder inputs, compare, advance model
  task automatic step(output bit acc);
    int  a;
    bit  hit, eWait, eReq, eWr;
    int  eAddr;
    memBusy    = (busyLeft > 0);
    memRdValid = (lat == 1);
    for (int i = 0; i < LB; i++) memRdLine[8*i +: 8] = memByte((mMiss & ~15) + i);
    #1;
    a   = int'(cpuAddr);
    hit = mValid && (mTag == (a >> 4));
    eWait = 0; eReq = 0; eWr = 0; eAddr = a;
    case (mSt)
      0: begin
        if (cpuRdReq) eWait = !hit;
        else if (cpuWrReq) begin eWait = memBusy; eReq = !memBusy; eWr = !memBusy; end
      end
      1: begin eWait = 1; eReq = !memBusy; eAddr = mMiss & ~15; end
      2: eWait = 1;
      default: eWait = cpuWrReq;
    endcase
    acc = (cpuRdReq || cpuWrReq) && !eWait;
    vectors++;
    chk("R1 R3 R4 R7 R10 cpuWait", cpuWait, eWait);
    chk("R3 R6 R7 R10 memReq", memReq, eReq);
    if (eReq) begin
      chk("R4 R7 memWrite", memWrite, eWr);
      chk("R4 R7 memAddr", int'(memAddr), eAddr);
      if (eWr) chk("R7 memWrData", memWrData, cpuWrData);
    end
    chk("R8 R10 mirWe", mirWe, eReq && eWr);
    if (eReq && eWr) begin
      chk("R8 mirAddr", int'(mirAddr), a);
      chk("R8 mirData", mirData, cpuWrData);
    end
    chk("R3 R5 cpuRdReady", cpuRdReady, mRdy);
    if (mRdy) chk("R2 R3 R5 R9 cpuRdData", cpuRdData, mData);
    @(posedge clk);
    mRdy = 0;
    case (mSt)
      0: begin
        if (cpuRdReq) begin
          if (hit) begin mRdy = 1; mData = mLine[a & 15]; end
          else begin mMiss = a; mSt = 1; end
        end else if (cpuWrReq && !memBusy) begin
          memArr[a] = cpuWrData;
          if (hit) mLine[a & 15] = cpuWrData;
        end
      end
      1: if (!memBusy) begin mSt = 2; lat = LAT + 1; end
      2: if (memRdValid) begin
        for (int i = 0; i < LB; i++) mLine[i] = memRdLine[8*i +: 8];
        mTag = mMiss >> 4; mValid = 1;
        mRdy = 1; mData = mLine[mMiss & 15]; mSt = 3;
      end
      default: mSt = 0;
    endcase
    if (lat > 0) lat--;
    if (busyLeft > 0) busyLeft--;
    #1;
  endtask

  task automatic idle(int n);
    bit acc;
    for (int i = 0; i < n; i++) step(acc);
  endtask

  task automatic doRead(int a);
    bit acc;
    cpuRdReq = 1; cpuAddr = AW'(a);
    for (int i = 0; i < 200; i++) begin step(acc); if (acc) break; end
    cpuRdReq = 0;
    step(acc);
  endtask

  task automatic doWrite(int a, int d);
    bit acc;
    cpuWrReq = 1; cpuAddr = AW'(a); cpuWrData = 8'(d);
    for (int i = 0; i < 200; i++) begin step(acc); if (acc) break; end
    cpuWrReq = 0;
    step(acc);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    bit acc;
    rstN = 0; cpuRdReq = 0; cpuWrReq = 0; cpuAddr = '0; cpuWrData = '0;
    memBusy = 0; memRdValid = 0; memRdLine = '0;
    mSt = 0; mValid = 0; mTag = 0; mMiss = 0; mRdy = 0; mData = 0;
    busyLeft = 0; lat = 0;
    for (int i = 0; i < LB; i++) mLine[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #0;
    // R1: quiet outputs after reset
    idle(3);

    // R2, R4, R5: first read misses; fetch held off by busy
    busyLeft = 4;
    doRead(16'h0123);
    // R3 and R5 byte order: hits across the line
    doRead(16'h0120);
    doRead(16'h012F);
    doRead(16'h0123);
    doRead(16'h0123);

    // R7, R8: write delayed by busy; R9: hit write patches the line
    busyLeft = 2;
    doWrite(16'h0125, 8'hA5);
    doRead(16'h0125);

    // R9: write outside line leaves held line; new line sees written byte
    doWrite(16'h0300, 8'h77);
    doRead(16'h0127);
    doRead(16'h0300);
    doRead(16'h0301);

    // R10: write to line being fetched is held through fill, then applied
    cpuRdReq = 1; cpuAddr = 16'h0450;
    step(acc); step(acc); step(acc);
    cpuRdReq = 0; cpuWrReq = 1; cpuAddr = 16'h0451; cpuWrData = 8'h3C;
    for (int i = 0; i < 50; i++) begin step(acc); if (acc) break; end
    cpuWrReq = 0;
    step(acc);
    doRead(16'h0451);
    doRead(16'h0450);

    // sweep of a fresh line, with busy on the fetch
    busyLeft = 1;
    for (int i = 0; i < LB; i++) doRead(16'h2A40 + i);
    // back-to-back hits without idle gaps
    cpuRdReq = 1;
    for (int i = 0; i < 8; i++) begin cpuAddr = AW'(16'h2A40 + 2*i); step(acc); end
    cpuRdReq = 0;
    idle(2);
    // mid-reset: line must be forgotten (R1, R2)
    rstN = 0;
    @(posedge clk);
    #1 rstN = 1;
    mSt = 0; mValid = 0; mRdy = 0; lat = 0; busyLeft = 0;
    idle(2);
    doRead(16'h2A41);
    idle(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule